// File: doc/BRIEF.md
# Two-Wire Bus Status Tracker

This block watches a two-wire serial bus and the local byte engine, and keeps an eight-bit status word for a host microcontroller. The bus clock and data lines enter raw. A parameterised flop chain synchronises them, and the block then finds start, repeated-start and stop conditions. A start or stop that arrives while the local engine reports a byte in progress counts as a bus error.

The shifter, the address comparator and the clock generator sit outside this block. Their outcomes arrive as strobes and levels: byte done, own-address match, general-call match, slave-receive mode, participation in the current transfer, the sampled bit, the direction bit, master-transmit drive state, local start issue, and byte in progress. The status flags depend on each other and on bus events. The host takes a snapshot of the word through a read strobe and releases the pending condition with an acknowledge strobe.

Top module: `tw_status_tracker`

## Requirements
- R1: After synchronous reset, all eight status bits are 0, and so is the read data.
- R2: A pulse on `host_rd` loads the status word into `rd_data` at the next clock edge. Bit order from 7 to 0 is: pending-not, repeated-start, stop-in-slave-receive, bus-error, direction/last-bit, addressed, arbitration-lost, bus-free. `rd_data` holds its value when `host_rd` is low, and reading changes no status bit.
- R3: An SDA fall while SCL is high (start) drives bit 0 to 0. An SDA rise while SCL is high (stop) drives bit 0 to 1. Each shows up within three clock edges of the line change. SDA changes while SCL is low have no effect.
- R4: `eng_byte_done` clears bit 7 to 0. `host_ack` sets bit 7 to 1. If both arrive in the same cycle, byte done wins.
- R5: Bit 6 is set by a start that arrives while a transfer is open (a start has been seen with no stop since) and `eng_involved` is high. A start with `eng_involved` low, or the first start of a transfer, leaves bit 6 at 0.
- R6: Bit 5 is set by a stop that arrives while `eng_slave_rx` is high. A stop with `eng_slave_rx` low leaves bit 5 at 0.
- R7: A start or stop while `eng_in_byte` is high sets bit 4 and forces bits 7 and 0 to 0. That event sets neither bit 6 nor bit 5.
- R8: `host_ack` clears bits 4, 5 and 6.
- R9: An address-match strobe (own or general call) loads `eng_rw_bit` into bit 3. Otherwise `eng_bit_valid` loads `eng_rx_bit` into bit 3. An address match takes priority over a sampled bit in the same cycle.
- R10: Bit 2 is set by `eng_addr_own` or `eng_addr_gc`, and is cleared by any start or stop.
- R11: Bit 1 is set when `eng_bit_valid` arrives with `eng_master_tx` and `eng_drive_high` high and `eng_rx_bit` low. It is cleared by `eng_start_issue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| eng_byte_done | input | 1 | Strobe: byte operation finished, host must act |
| eng_addr_own | input | 1 | Strobe: received address matched own address |
| eng_addr_gc | input | 1 | Strobe: received address was general call |
| eng_slave_rx | input | 1 | Level: engine is in slave receive mode |
| eng_involved | input | 1 | Level: this node takes part in the current transfer |
| eng_bit_valid | input | 1 | Strobe: a bus bit was sampled |
| eng_rx_bit | input | 1 | Value of the sampled bit |
| eng_rw_bit | input | 1 | Direction bit of the matched address, 1 = read |
| eng_master_tx | input | 1 | Level: engine is transmitting as master |
| eng_drive_high | input | 1 | Level: engine releases SDA high for the current bit |
| eng_start_issue | input | 1 | Strobe: this node issues a start |
| eng_in_byte | input | 1 | Level: a byte is being shifted |
| host_ack | input | 1 | Strobe: host releases pending state and sticky flags |
| host_rd | input | 1 | Strobe: capture status into read data |
| rd_data | output | 8 | Captured status word |

## Verification
All state is visible only through `rd_data`, so any fault becomes visible at the first read after the disturbing event. A transfer-open flag that is lost or stuck makes bit 6 differ on the next repeated start. A synchroniser chain that is off by a stage shows up as bit 0 lagging, or as false conditions when SDA moves while SCL is low. Because the coupled flags are read as whole words after each event, an error that fails to force bits 7 and 0 appears as a word mismatch in the same read.

// File: rtl/tw_stat_pkg.sv
package tw_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int SYNC_DEF = 2;

    // Bit positions inside the host status word; bench and host rely on them.
    localparam int B_PIN  = 7;
    localparam int B_RPT  = 6;
    localparam int B_SRX  = 5;
    localparam int B_ERR  = 4;
    localparam int B_DIR  = 3;
    localparam int B_ADR  = 2;
    localparam int B_LOST = 1;
    localparam int B_FREE = 0;

    typedef struct packed {
        logic pend_n;
        logic rpt_start;
        logic stop_srx;
        logic bus_err;
        logic dir_bit;
        logic addressed;
        logic arb_lost;
        logic free_n;
    } stat_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic err;
    } bus_ev_t;

    typedef struct packed {
        logic byte_done;
        logic addr_own;
        logic addr_gc;
        logic slave_rx;
        logic involved;
        logic bit_valid;
        logic rx_bit;
        logic rw_bit;
        logic master_tx;
        logic drive_high;
        logic start_issue;
        logic in_byte;
    } eng_t;

    // Sticky flag update: a set request beats a clear request.
    function automatic logic sticky(input logic cur, input logic set_i, input logic clr_i);
        if (set_i)      return 1'b1;
        else if (clr_i) return 1'b0;
        else            return cur;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int W       = 2,
    parameter int STAGES  = 2,
    parameter logic RST_V = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{{W{RST_V}}}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
    import tw_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    input  logic    in_byte,
    output bus_ev_t ev
);
    logic scl_d, sda_d;
    logic clk_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SCL must be high on both samples around the SDA transition.
    assign clk_high = scl_s & scl_d;

    always_comb begin
        ev.start = clk_high &  sda_d & ~sda_s;
        ev.stop  = clk_high & ~sda_d &  sda_s;
        ev.err   = (ev.start | ev.stop) & in_byte;
    end
endmodule

// File: rtl/tw_status_flags.sv
module tw_status_flags
    import tw_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  eng_t    eng,
    input  logic    host_ack,
    output stat_t   st
);
    logic  xfer_open;
    logic  addr_hit;
    logic  clean_start, clean_stop;
    logic  lost_bit;
    stat_t nx;

    assign addr_hit    = eng.addr_own | eng.addr_gc;
    assign clean_start = ev.start & ~ev.err;
    assign clean_stop  = ev.stop  & ~ev.err;
    assign lost_bit    = eng.bit_valid & eng.master_tx & eng.drive_high & ~eng.rx_bit;

    always_comb begin
        nx = st;

        // bus-free (active low busy indicator)
        if (ev.err)            nx.free_n = 1'b0;
        else if (ev.start)     nx.free_n = 1'b0;
        else if (ev.stop)      nx.free_n = 1'b1;

        // pending-not
        if (ev.err || eng.byte_done) nx.pend_n = 1'b0;
        else if (host_ack)           nx.pend_n = 1'b1;

        nx.bus_err   = sticky(st.bus_err,   ev.err, host_ack);
        nx.rpt_start = sticky(st.rpt_start, clean_start & xfer_open & eng.involved, host_ack);
        nx.stop_srx  = sticky(st.stop_srx,  clean_stop & eng.slave_rx, host_ack);

        if (addr_hit)           nx.dir_bit = eng.rw_bit;
        else if (eng.bit_valid) nx.dir_bit = eng.rx_bit;

        nx.addressed = sticky(st.addressed, addr_hit, ev.start | ev.stop);
        nx.arb_lost  = sticky(st.arb_lost,  lost_bit, eng.start_issue);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            xfer_open <= 1'b0;
        end else begin
            st <= nx;
            if (ev.err || ev.stop) xfer_open <= 1'b0;
            else if (ev.start)     xfer_open <= 1'b1;
        end
    end
endmodule

// File: rtl/tw_status_tracker.sv
module tw_status_tracker
    import tw_stat_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              eng_byte_done,
    input  logic              eng_addr_own,
    input  logic              eng_addr_gc,
    input  logic              eng_slave_rx,
    input  logic              eng_involved,
    input  logic              eng_bit_valid,
    input  logic              eng_rx_bit,
    input  logic              eng_rw_bit,
    input  logic              eng_master_tx,
    input  logic              eng_drive_high,
    input  logic              eng_start_issue,
    input  logic              eng_in_byte,
    input  logic              host_ack,
    input  logic              host_rd,
    output logic [STAT_W-1:0] rd_data
);
    logic [1:0]        line_s;
    bus_ev_t           ev;
    eng_t              eng;
    stat_t             st;
    logic [STAT_W-1:0] status_bits;
    logic              ev_start, ev_stop, ev_err;

    tw_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    tw_cond_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .scl_s   (line_s[1]),
        .sda_s   (line_s[0]),
        .in_byte (eng_in_byte),
        .ev      (ev)
    );

    always_comb begin
        eng.byte_done   = eng_byte_done;
        eng.addr_own    = eng_addr_own;
        eng.addr_gc     = eng_addr_gc;
        eng.slave_rx    = eng_slave_rx;
        eng.involved    = eng_involved;
        eng.bit_valid   = eng_bit_valid;
        eng.rx_bit      = eng_rx_bit;
        eng.rw_bit      = eng_rw_bit;
        eng.master_tx   = eng_master_tx;
        eng.drive_high  = eng_drive_high;
        eng.start_issue = eng_start_issue;
        eng.in_byte     = eng_in_byte;
    end

    tw_status_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .eng      (eng),
        .host_ack (host_ack),
        .st       (st)
    );

    assign status_bits = st;
    assign ev_start    = ev.start;
    assign ev_stop     = ev.stop;
    assign ev_err      = ev.err;

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (host_rd) rd_data <= status_bits;
    end
endmodule

// File: rtl/tw_status_chk.sv
module tw_status_chk
    import tw_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [STAT_W-1:0] st,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_err,
    input logic              byte_done,
    input logic              host_ack,
    input logic              involved,
    input logic              slave_rx,
    input logic              addr_own,
    input logic              addr_gc,
    input logic              host_rd,
    input logic [STAT_W-1:0] rd_data
);
    assert_err_forces_R7: assert property (@(posedge clk) disable iff (rst)
        ev_err |=> (st[B_ERR] && !st[B_PIN] && !st[B_FREE]));

    assert_done_pends_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_done && !ev_err) |=> !st[B_PIN]);

    assert_ack_releases_R4: assert property (@(posedge clk) disable iff (rst)
        (host_ack && !byte_done && !ev_err) |=> st[B_PIN]);

    assert_rpt_needs_part_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(st[B_RPT]) |-> ($past(involved) && $past(ev_start)));

    assert_srx_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st[B_SRX]) |-> ($past(slave_rx) && $past(ev_stop)));

    assert_stop_frees_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_err) |=> st[B_FREE]);

    assert_rd_capture_R2: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> (rd_data == $past(st)));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(rd_data));

    assert_addr_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(st[B_ADR]) |-> $past(addr_own || addr_gc));
endmodule

bind tw_status_tracker tw_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (status_bits),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_err    (ev_err),
    .byte_done (eng_byte_done),
    .host_ack  (host_ack),
    .involved  (eng_involved),
    .slave_rx  (eng_slave_rx),
    .addr_own  (eng_addr_own),
    .addr_gc   (eng_addr_gc),
    .host_rd   (host_rd),
    .rd_data   (rd_data)
);

// File: tb/sim_tw_status_tracker.sv
module sim_tw_status_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1;
    logic byte_done = 0, addr_own = 0, addr_gc = 0, slave_rx = 0, involved = 0;
    logic bit_valid = 0, rx_bit = 0, rw_bit = 0, master_tx = 0, drive_high = 0;
    logic start_issue = 0, in_byte = 0, host_ack = 0, host_rd = 0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_status_tracker u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .eng_byte_done(byte_done), .eng_addr_own(addr_own), .eng_addr_gc(addr_gc),
        .eng_slave_rx(slave_rx), .eng_involved(involved), .eng_bit_valid(bit_valid),
        .eng_rx_bit(rx_bit), .eng_rw_bit(rw_bit), .eng_master_tx(master_tx),
        .eng_drive_high(drive_high), .eng_start_issue(start_issue),
        .eng_in_byte(in_byte), .host_ack(host_ack), .host_rd(host_rd),
        .rd_data(rd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic c, input logic d);
        scl = c; sda = d;
        tick(4);
    endtask

    task automatic ack();
        host_ack = 1; tick(1); host_ack = 0;
    endtask

    task automatic rd_chk(input logic [7:0] exp, input logic [7:0] mask, input string tag);
        host_rd = 1; tick(1); host_rd = 0;
        checks++;
        if ((rd_data & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h (mask %02h)", tag, rd_data, exp, mask);
        end
    endtask

    initial begin
        tick(WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        tick(3);
        rst = 0;
        tick(1);
        checks++;
        if (rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R1: got %02h expected 00", rd_data);
        end
        rd_chk(8'h00, 8'hFF, "R1 status after reset");

        // R3: stop from a low-data state frees the bus
        bus(0, 0); bus(1, 0); bus(1, 1);
        rd_chk(8'h01, 8'hFF, "R3 stop sets bit0");

        // R3: SDA toggles while SCL low are ignored
        for (int i = 0; i < 4; i++) begin
            bus(0, i[0]);
            rd_chk(8'h01, 8'hFF, "R3 SDA with SCL low ignored");
        end
        bus(0, 1);

        // R3/R5: first start marks bus busy, no repeated start
        bus(1, 1); bus(1, 0);
        rd_chk(8'h00, 8'hFF, "R3 R5 first start");

        // R4: pending-not handling
        ack();
        rd_chk(8'h80, 8'hFF, "R4 ack sets bit7");
        byte_done = 1; tick(1); byte_done = 0;
        rd_chk(8'h00, 8'hFF, "R4 byte done clears bit7");
        byte_done = 1; host_ack = 1; tick(1); byte_done = 0; host_ack = 0;
        rd_chk(8'h00, 8'hFF, "R4 byte done beats ack");
        ack();

        // R5: repeated start, not involved then involved
        bus(0, 0); bus(0, 1); bus(1, 1); bus(1, 0);
        rd_chk(8'h80, 8'hFF, "R5 repeated start not involved");
        involved = 1;
        bus(0, 0); bus(0, 1); bus(1, 1); bus(1, 0);
        rd_chk(8'hC0, 8'hFF, "R5 repeated start involved");
        involved = 0;
        ack();
        rd_chk(8'h80, 8'hFF, "R8 ack clears bit6");

        // R6: stop in slave receive
        bus(0, 0); bus(1, 0);
        slave_rx = 1; bus(1, 1); slave_rx = 0;
        rd_chk(8'hA1, 8'hFF, "R6 stop in slave receive");
        ack();
        rd_chk(8'h81, 8'hFF, "R8 ack clears bit5");
        bus(1, 0);
        rd_chk(8'h80, 8'hFF, "R5 start after stop is first start");
        bus(0, 0); bus(1, 0); bus(1, 1);
        rd_chk(8'h81, 8'hFF, "R6 stop outside slave receive");

        // R7: misplaced start
        in_byte = 1; bus(1, 0); in_byte = 0;
        rd_chk(8'h10, 8'hFF, "R7 misplaced start");
        ack();
        rd_chk(8'h80, 8'hFF, "R8 ack clears bit4");
        // R7: misplaced stop in slave receive sets no bit5
        bus(0, 0); bus(1, 0);
        in_byte = 1; slave_rx = 1; bus(1, 1); in_byte = 0; slave_rx = 0;
        rd_chk(8'h10, 8'hFF, "R7 misplaced stop");
        ack();
        rd_chk(8'h80, 8'hFE, "R8 ack after misplaced stop");

        // R9/R10: address match sweep
        for (int t = 0; t < 4; t++) begin
            logic rw;
            rw = t[1];
            addr_own = ~t[0]; addr_gc = t[0]; rw_bit = rw;
            bit_valid = 1; rx_bit = ~rw;
            tick(1);
            addr_own = 0; addr_gc = 0; bit_valid = 0;
            rd_chk(8'h84 | (rw ? 8'h08 : 8'h00), 8'hFE, "R9 R10 address match with priority");
            bit_valid = 1; rx_bit = ~rw; tick(1); bit_valid = 0;
            rd_chk(8'h04 | (rw ? 8'h00 : 8'h08), 8'h0C, "R9 sampled bit loads bit3");
            bus(1, 0); bus(0, 0); bus(1, 0); bus(1, 1);
            rd_chk(8'h01, 8'h05, "R10 start/stop clears bit2");
        end

        // R11: arbitration-lost sweep
        for (int k = 0; k < 8; k++) begin
            master_tx = k[2]; drive_high = k[1]; rx_bit = k[0];
            bit_valid = 1; tick(1); bit_valid = 0;
            rd_chk((k[2] & k[1] & ~k[0]) ? 8'h02 : 8'h00, 8'h02, "R11 lost condition");
            start_issue = 1; tick(1); start_issue = 0;
            rd_chk(8'h00, 8'h02, "R11 local start clears");
        end
        master_tx = 0; drive_high = 0;

        // R2: reads have no side effect, bit layout via a known word
        ack();
        host_rd = 1; tick(1); host_rd = 0;
        prev = rd_data;
        tick(2);
        rd_chk(prev, 8'hFF, "R2 repeated read unchanged");
        checks++;
        if (prev[7] !== 1'b1 || prev[0] !== 1'b1) begin
            fails++;
            $display("FAIL R2: got %02h expected bit7=1 bit0=1", prev);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule